// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This combinational block takes a 32-bit virtual address and sorts it into one of five fixed regions of the address map. The regions are the low user half, two unmapped kernel windows, a supervisor window and a top kernel window. The block checks the access against the current privilege mode and the error-level flag. It then does one of three things: it translates the address on the spot, it hands the address to an external page-table cache (TLB), or it declares a fault.

The TLB answers in the same cycle with a hit flag, an entry-valid flag, an entry-dirty flag and a full physical address. When translation fails, the block reports an exception code and a refill flag. It also computes the next values of three fault registers: the faulting address, the context register and the entry-high register. The three fault-register values are meaningful only while the fault-valid output is high. A processor pipeline places the block between address generation and the memory request.

Top module: `seg_addr_decoder`

## Requirements
- R1: For an address below 0x80000000 with the error-level flag set, the physical address equals the virtual address. Read and write are both granted, no TLB request is made and no fault is raised, in every mode.
- R2: The TLB request output is high exactly for addresses below 0x80000000 with the error-level flag clear, and for the 0xC0000000-0xFFFFFFFF range when that range is permitted in the current mode. In all other cases the TLB inputs have no effect on any output.
- R3: In kernel mode, an address in 0x80000000-0x9FFFFFFF translates to the address minus 0x80000000, with read and write granted.
- R4: In kernel mode, an address in 0xA0000000-0xBFFFFFFF translates to the address minus 0xA0000000, with read and write granted.
- R5: Addresses in 0xC0000000-0xDFFFFFFF go to the TLB in supervisor or kernel mode. In user mode they fault as a bad address.
- R6: Addresses at 0xE0000000 and above go to the TLB only in kernel mode. In the other modes they fault as a bad address.
- R7: The mode is encoded as follows: 2'b01 is supervisor, 2'b10 is user, and both 2'b00 and 2'b11 are kernel. Outside kernel mode, any access to 0x80000000-0xBFFFFFFF faults as a bad address.
- R8: For a TLB hit on a valid entry, when the access is a read or the entry is dirty, the physical address is the TLB physical address. Read is granted, and write is granted exactly when the entry is dirty.
- R9: The exception code is a 5-bit value. A bad address gives 4 on a read and 5 on a write. A TLB miss gives 2 on a read and 3 on a write, with the refill flag set. A hit on an invalid entry gives the same codes with the refill flag clear. A write to a valid clean entry gives 1. The fault-valid output is high for every fault.
- R10: On a fault, the faulting-address output equals the virtual address.
- R11: On a fault, the next context value is built as follows: bits 31:23 are copied from the current context, bits 22:4 hold virtual address bits 31:13, and bits 3:0 are zero.
- R12: On a fault, the next entry-high value is built as follows: bits 7:0 are copied from the current entry-high (the address-space ID), bits 31:13 hold virtual address bits 31:13, and bits 12:8 are zero.
- R13: Without a fault, the fault-valid output, exception code, refill flag and all three fault-register outputs are zero. On a fault, the physical address and both permission bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vAddr | input | 32 | Virtual address to decode |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| mode | input | 2 | Privilege mode (01 supervisor, 10 user, else kernel) |
| errorLevel | input | 1 | Error-level flag; bypasses the TLB for the user half |
| contextCur | input | 32 | Current context register value |
| entryHiCur | input | 32 | Current entry-high register value |
| tlbReq | output | 1 | Lookup request to the TLB |
| tlbHit | input | 1 | TLB found a matching entry |
| tlbEntryValid | input | 1 | Valid bit of the matched page half |
| tlbEntryDirty | input | 1 | Dirty (writable) bit of the matched page half |
| tlbPhysAddr | input | 32 | Physical address returned by the TLB |
| physAddr | output | 32 | Translated physical address |
| permRead | output | 1 | Read granted |
| permWrite | output | 1 | Write granted |
| faultValid | output | 1 | Translation failed; fault outputs are valid |
| excCode | output | 5 | Exception code |
| tlbRefill | output | 1 | Failure was a TLB miss (refill case) |
| badVAddrNext | output | 32 | Next faulting-address register value |
| contextNext | output | 32 | Next context register value |
| entryHiNext | output | 32 | Next entry-high register value |

## Verification
The bench applies directed vectors at each segment boundary, using the first and last address of every region. A decoder with an off-by-one range compare would send 0xBFFFFFFF to the supervisor window, or would treat 0xC0000000 as unmapped. Every mode encoding, including the spare code 11, is tried against the kernel-only windows; a design that decoded kernel as 00 alone would fault valid kernel accesses. The bench also covers TLB results that differ only in the dirty bit on a read, and in the valid bit on a miss. These catch a swapped refill flag or a write permission granted to a clean page. Random vectors with noisy TLB inputs on unmapped addresses confirm that those inputs leak into no output. They also confirm that the preserved context and entry-high bits never take address bits.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

  localparam int ADDR_W = 32;
  localparam int EXC_W  = 5;

  // region bases of the fixed map
  localparam logic [ADDR_W-1:0] KWIN0_BASE = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] KWIN1_BASE = 32'hA000_0000;

  // exception codes
  localparam logic [EXC_W-1:0] EXC_NONE  = 5'd0;
  localparam logic [EXC_W-1:0] EXC_MOD   = 5'd1;
  localparam logic [EXC_W-1:0] EXC_TLBLD = 5'd2;
  localparam logic [EXC_W-1:0] EXC_TLBST = 5'd3;
  localparam logic [EXC_W-1:0] EXC_ADLD  = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADST  = 5'd5;

  typedef enum logic [2:0] {
    REG_USER,
    REG_KWIN0,
    REG_KWIN1,
    REG_SUPWIN,
    REG_KTOP
  } region_e;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_BADADDR,
    FK_MISS,
    FK_INVALID,
    FK_CLEAN
  } faultKind_e;

  typedef enum logic [1:0] {
    PS_PASS,
    PS_KWIN0,
    PS_KWIN1,
    PS_TLB
  } physSel_e;

  typedef struct packed {
    physSel_e physSel;
    logic     faultLoad;
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_dec_ctrl.sv
module seg_dec_ctrl
  import seg_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] vAddr,
  input  logic              isWrite,
  input  logic [1:0]        mode,
  input  logic              errorLevel,
  input  logic              tlbHit,
  input  logic              tlbEntryValid,
  input  logic              tlbEntryDirty,
  output logic              tlbReq,
  output logic              permRead,
  output logic              permWrite,
  output logic [EXC_W-1:0]  excCode,
  output logic              tlbRefill,
  output ctrlStrobe_t       strobe
);

  logic       isUser;
  logic       isSuper;
  logic       isKernel;
  region_e    region;
  faultKind_e faultKind;
  logic       mapped;
  logic       unmappedOk;
  physSel_e   unmappedSel;

  assign isUser   = (mode == 2'b10);
  assign isSuper  = (mode == 2'b01);
  assign isKernel = !isUser && !isSuper;

  // region from the top address bits
  always_comb begin
    if (!vAddr[ADDR_W-1]) begin
      region = REG_USER;
    end else begin
      unique case (vAddr[ADDR_W-2:ADDR_W-3])
        2'b00:   region = REG_KWIN0;
        2'b01:   region = REG_KWIN1;
        2'b10:   region = REG_SUPWIN;
        default: region = REG_KTOP;
      endcase
    end
  end

  // privilege gate and path choice
  always_comb begin
    mapped      = 1'b0;
    unmappedOk  = 1'b0;
    unmappedSel = PS_PASS;
    unique case (region)
      REG_USER: begin
        if (errorLevel) begin
          unmappedOk  = 1'b1;
          unmappedSel = PS_PASS;
        end else begin
          mapped = 1'b1;
        end
      end
      REG_KWIN0: begin
        unmappedOk  = isKernel;
        unmappedSel = PS_KWIN0;
      end
      REG_KWIN1: begin
        unmappedOk  = isKernel;
        unmappedSel = PS_KWIN1;
      end
      REG_SUPWIN: mapped = isKernel || isSuper;
      default:    mapped = isKernel;
    endcase
  end

  assign tlbReq = mapped;

  // failure kind and permissions
  always_comb begin
    faultKind = FK_NONE;
    permRead  = 1'b0;
    permWrite = 1'b0;
    strobe.physSel = unmappedSel;
    if (mapped) begin
      strobe.physSel = PS_TLB;
      if (!tlbHit) begin
        faultKind = FK_MISS;
      end else if (!tlbEntryValid) begin
        faultKind = FK_INVALID;
      end else if (isWrite && !tlbEntryDirty) begin
        faultKind = FK_CLEAN;
      end else begin
        permRead  = 1'b1;
        permWrite = tlbEntryDirty;
      end
    end else if (unmappedOk) begin
      permRead  = 1'b1;
      permWrite = 1'b1;
    end else begin
      faultKind = FK_BADADDR;
    end
    strobe.faultLoad = (faultKind != FK_NONE);
  end

  // failure kind to exception code
  always_comb begin
    tlbRefill = 1'b0;
    unique case (faultKind)
      FK_BADADDR: excCode = isWrite ? EXC_ADST : EXC_ADLD;
      FK_MISS: begin
        excCode   = isWrite ? EXC_TLBST : EXC_TLBLD;
        tlbRefill = 1'b1;
      end
      FK_INVALID: excCode = isWrite ? EXC_TLBST : EXC_TLBLD;
      FK_CLEAN:   excCode = EXC_MOD;
      default:    excCode = EXC_NONE;
    endcase
  end

  // checks next to the gate and the code map
  always_comb begin
    if (mode == 2'b10 && vAddr[ADDR_W-1]) begin
      a_r7_user_upper_faults: assert (strobe.faultLoad && (excCode == EXC_ADLD || excCode == EXC_ADST));
    end
    if (tlbReq) begin
      a_r2_req_only_mapped: assert (vAddr[ADDR_W-1:ADDR_W-2] != 2'b10 && !(errorLevel && !vAddr[ADDR_W-1]));
    end
    if (tlbRefill) begin
      a_r9_refill_on_miss: assert (!tlbHit && (excCode == EXC_TLBLD || excCode == EXC_TLBST));
    end
    if (tlbReq && permWrite) begin
      a_r8_write_needs_dirty: assert (tlbEntryDirty && tlbHit && tlbEntryValid);
    end
  end

endmodule

// File: rtl/seg_dec_dp.sv
module seg_dec_dp
  import seg_dec_pkg::*;
#(
  parameter int ASID_W     = 8,
  parameter int PAIR_SHIFT = 13,
  parameter int CTX_LSB    = 4
) (
  input  logic [ADDR_W-1:0] vAddr,
  input  logic [ADDR_W-1:0] contextCur,
  input  logic [ADDR_W-1:0] entryHiCur,
  input  logic [ADDR_W-1:0] tlbPhysAddr,
  input  ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] badVAddrNext,
  output logic [ADDR_W-1:0] contextNext,
  output logic [ADDR_W-1:0] entryHiNext
);

  localparam int VPN2_W  = ADDR_W - PAIR_SHIFT;
  localparam int CTX_TOP = CTX_LSB + VPN2_W;
  localparam int EHI_GAP = PAIR_SHIFT - ASID_W;

  logic [VPN2_W-1:0] vpn2;
  logic [ADDR_W-1:0] ctxForm;
  logic [ADDR_W-1:0] ehiForm;
  logic [ADDR_W-1:0] transAddr;
  logic              unusedBits;

  assign vpn2 = vAddr[ADDR_W-1:PAIR_SHIFT];

  // translated address selection
  always_comb begin
    unique case (strobe.physSel)
      PS_KWIN0: transAddr = vAddr - KWIN0_BASE;
      PS_KWIN1: transAddr = vAddr - KWIN1_BASE;
      PS_TLB:   transAddr = tlbPhysAddr;
      default:  transAddr = vAddr;
    endcase
  end

  // fault register forms
  generate
    if (CTX_TOP < ADDR_W) begin : g_ctxKeep
      assign ctxForm = {contextCur[ADDR_W-1:CTX_TOP], vpn2, {CTX_LSB{1'b0}}};
    end else begin : g_ctxFull
      assign ctxForm = {vpn2, {CTX_LSB{1'b0}}};
    end
    if (EHI_GAP > 0) begin : g_ehiGap
      assign ehiForm = {vpn2, {EHI_GAP{1'b0}}, entryHiCur[ASID_W-1:0]};
    end else begin : g_ehiTight
      assign ehiForm = {vpn2, entryHiCur[ASID_W-1:0]};
    end
  endgenerate

  assign physAddr     = strobe.faultLoad ? '0 : transAddr;
  assign badVAddrNext = strobe.faultLoad ? vAddr : '0;
  assign contextNext  = strobe.faultLoad ? ctxForm : '0;
  assign entryHiNext  = strobe.faultLoad ? ehiForm : '0;

  assign unusedBits = ^{contextCur, entryHiCur};

  always_comb begin
    if (strobe.faultLoad) begin
      a_r11_context_upper_kept: assert (contextNext[ADDR_W-1:CTX_TOP] == contextCur[ADDR_W-1:CTX_TOP]
                                        && contextNext[CTX_LSB-1:0] == '0);
      a_r12_asid_kept: assert (entryHiNext[ASID_W-1:0] == entryHiCur[ASID_W-1:0]);
      a_r13_no_phys_on_fault: assert (physAddr == '0);
    end else begin
      a_r13_quiet_regs: assert (badVAddrNext == '0 && contextNext == '0 && entryHiNext == '0);
    end
    if (!strobe.faultLoad && (strobe.physSel == PS_KWIN0 || strobe.physSel == PS_KWIN1)) begin
      a_r3_window_low: assert (physAddr[ADDR_W-1:ADDR_W-3] == 3'b000 && physAddr[ADDR_W-4:0] == vAddr[ADDR_W-4:0]);
    end
  end

endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
  import seg_dec_pkg::*;
#(
  parameter int ASID_W     = 8,
  parameter int PAIR_SHIFT = 13,
  parameter int CTX_LSB    = 4
) (
  input  logic [31:0] vAddr,
  input  logic        isWrite,
  input  logic [1:0]  mode,
  input  logic        errorLevel,
  input  logic [31:0] contextCur,
  input  logic [31:0] entryHiCur,
  output logic        tlbReq,
  input  logic        tlbHit,
  input  logic        tlbEntryValid,
  input  logic        tlbEntryDirty,
  input  logic [31:0] tlbPhysAddr,
  output logic [31:0] physAddr,
  output logic        permRead,
  output logic        permWrite,
  output logic        faultValid,
  output logic [4:0]  excCode,
  output logic        tlbRefill,
  output logic [31:0] badVAddrNext,
  output logic [31:0] contextNext,
  output logic [31:0] entryHiNext
);

  ctrlStrobe_t strobe;

  seg_dec_ctrl i_ctrl (
    .vAddr         (vAddr),
    .isWrite       (isWrite),
    .mode          (mode),
    .errorLevel    (errorLevel),
    .tlbHit        (tlbHit),
    .tlbEntryValid (tlbEntryValid),
    .tlbEntryDirty (tlbEntryDirty),
    .tlbReq        (tlbReq),
    .permRead      (permRead),
    .permWrite     (permWrite),
    .excCode       (excCode),
    .tlbRefill     (tlbRefill),
    .strobe        (strobe)
  );

  seg_dec_dp #(
    .ASID_W     (ASID_W),
    .PAIR_SHIFT (PAIR_SHIFT),
    .CTX_LSB    (CTX_LSB)
  ) i_dp (
    .vAddr        (vAddr),
    .contextCur   (contextCur),
    .entryHiCur   (entryHiCur),
    .tlbPhysAddr  (tlbPhysAddr),
    .strobe       (strobe),
    .physAddr     (physAddr),
    .badVAddrNext (badVAddrNext),
    .contextNext  (contextNext),
    .entryHiNext  (entryHiNext)
  );

  assign faultValid = strobe.faultLoad;

endmodule

// File: tb/test_seg_addr_decoder.sv
module test_seg_addr_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vAddr = '0;
  logic        isWrite = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        errorLevel = 1'b0;
  logic [31:0] contextCur = '0;
  logic [31:0] entryHiCur = '0;
  logic        tlbReq;
  logic        tlbHit = 1'b0;
  logic        tlbEntryValid = 1'b0;
  logic        tlbEntryDirty = 1'b0;
  logic [31:0] tlbPhysAddr = '0;
  logic [31:0] physAddr;
  logic        permRead;
  logic        permWrite;
  logic        faultValid;
  logic [4:0]  excCode;
  logic        tlbRefill;
  logic [31:0] badVAddrNext;
  logic [31:0] contextNext;
  logic [31:0] entryHiNext;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seg_addr_decoder i_seg_addr_decoder (.*);

  typedef struct {
    bit          req;
    logic [31:0] pa;
    bit          rd;
    bit          wr;
    bit          flt;
    logic [4:0]  code;
    bit          refill;
    logic [31:0] bva;
    logic [31:0] ctx;
    logic [31:0] ehi;
    string       tag;
  } exp_t;

  function automatic exp_t model(logic [31:0] a, bit w, logic [1:0] m, bit erl,
                                 logic [31:0] ctxIn, logic [31:0] ehiIn,
                                 bit hit, bit vld, bit drt, logic [31:0] tpa);
    exp_t e;
    bit kern = (m == 2'b00) || (m == 2'b11);
    bit sup  = (m == 2'b01);
    bit viaTlb = 0;
    bit bad = 0;
    e = '{default: 0};
    e.tag = "R2";
    if (a < 32'h8000_0000) begin
      if (erl) begin e.pa = a; e.rd = 1; e.wr = 1; e.tag = "R1"; end
      else viaTlb = 1;
    end else if (a < 32'hA000_0000) begin
      e.tag = kern ? "R3" : "R7";
      if (kern) begin e.pa = a - 32'h8000_0000; e.rd = 1; e.wr = 1; end else bad = 1;
    end else if (a < 32'hC000_0000) begin
      e.tag = kern ? "R4" : "R7";
      if (kern) begin e.pa = a - 32'hA000_0000; e.rd = 1; e.wr = 1; end else bad = 1;
    end else if (a < 32'hE000_0000) begin
      e.tag = "R5";
      if (kern || sup) viaTlb = 1; else bad = 1;
    end else begin
      e.tag = "R6";
      if (kern) viaTlb = 1; else bad = 1;
    end
    if (viaTlb) begin
      e.req = 1;
      if (!hit) begin e.flt = 1; e.code = w ? 5'd3 : 5'd2; e.refill = 1; end
      else if (!vld) begin e.flt = 1; e.code = w ? 5'd3 : 5'd2; end
      else if (w && !drt) begin e.flt = 1; e.code = 5'd1; end
      else begin e.pa = tpa; e.rd = 1; e.wr = drt; end
    end
    if (bad) begin e.flt = 1; e.code = w ? 5'd5 : 5'd4; end
    if (e.flt) begin
      e.pa = '0; e.rd = 0; e.wr = 0;
      e.bva = a;
      e.ctx = (ctxIn & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
      e.ehi = (ehiIn & 32'h0000_00FF) | (a & 32'hFFFF_E000);
    end
    return e;
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, bit w, logic [1:0] m, bit erl,
                       logic [31:0] ctxIn, logic [31:0] ehiIn,
                       bit hit, bit vld, bit drt, logic [31:0] tpa);
    exp_t e;
    @(posedge clk);
    vAddr = a; isWrite = w; mode = m; errorLevel = erl;
    contextCur = ctxIn; entryHiCur = ehiIn;
    tlbHit = hit; tlbEntryValid = vld; tlbEntryDirty = drt; tlbPhysAddr = tpa;
    e = model(a, w, m, erl, ctxIn, ehiIn, hit, vld, drt, tpa);
    @(negedge clk);
    check32("R2", "tlbReq", {31'b0, tlbReq}, {31'b0, e.req});
    check32(e.tag, "physAddr", physAddr, e.pa);
    check32(e.flt ? "R13" : e.tag, "perm", {30'b0, permRead, permWrite}, {30'b0, e.rd, e.wr});
    check32("R9", "fault/code/refill", {25'b0, faultValid, excCode, tlbRefill},
            {25'b0, e.flt, e.code, e.refill});
    check32(e.flt ? "R10" : "R13", "badVAddr", badVAddrNext, e.bva);
    check32(e.flt ? "R11" : "R13", "context", contextNext, e.ctx);
    check32(e.flt ? "R12" : "R13", "entryHi", entryHiNext, e.ehi);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // R13 initial state with idle inputs: kernel user-half miss
    @(negedge clk);
    check32("R13", "idle faultValid", {31'b0, faultValid}, 32'd1);
    check32("R9", "idle excCode", {27'b0, excCode}, 32'd2);

    // R1 error-level pass-through in every mode, noisy TLB inputs
    for (int m = 0; m < 4; m++)
      apply(32'h7FFF_FFFC, 1'b1, m[1:0], 1'b1, 32'h1234_5678, 32'hABCD_EF12, 1, 0, 0, 32'hDEAD_BEEF);
    apply(32'h0000_0000, 1'b0, 2'b10, 1'b1, '0, '0, 0, 0, 0, '0);

    // R3 R4 window edges in kernel, both kernel codes
    apply(32'h8000_0000, 1'b1, 2'b00, 1'b0, '0, '0, 1, 1, 0, 32'h5555_5555);
    apply(32'h9FFF_FFFF, 1'b0, 2'b11, 1'b0, '0, '0, 0, 0, 0, '0);
    apply(32'hA000_0000, 1'b1, 2'b11, 1'b0, '0, '0, 1, 1, 1, 32'h1111_1111);
    apply(32'hBFFF_FFFF, 1'b0, 2'b00, 1'b0, '0, '0, 0, 0, 0, '0);

    // R7 kernel windows from supervisor and user
    apply(32'h8000_1000, 1'b0, 2'b01, 1'b0, 32'hFFFF_FFFF, 32'h0000_0042, 1, 1, 1, '0);
    apply(32'hBFFF_F000, 1'b1, 2'b10, 1'b0, 32'h0F80_000F, 32'hFFFF_FF99, 1, 1, 1, '0);

    // R5 R6 boundaries per mode
    apply(32'hC000_0000, 1'b0, 2'b01, 1'b0, '0, '0, 1, 1, 0, 32'h0ABC_D000);
    apply(32'hDFFF_FFFF, 1'b0, 2'b10, 1'b0, '0, '0, 1, 1, 1, '0);
    apply(32'hE000_0000, 1'b0, 2'b01, 1'b0, '0, '0, 1, 1, 1, '0);
    apply(32'hFFFF_FFFF, 1'b1, 2'b11, 1'b0, '0, '0, 1, 1, 1, 32'h0000_2FFF);

    // R8 R9 TLB outcomes
    apply(32'h0040_2000, 1'b0, 2'b10, 1'b0, 32'hAA55_AA55, 32'h0000_0007, 1, 1, 0, 32'h0123_4000);
    apply(32'h0040_2000, 1'b1, 2'b10, 1'b0, 32'hAA55_AA55, 32'h0000_0007, 1, 1, 0, '0);
    apply(32'h0040_2000, 1'b1, 2'b10, 1'b0, 32'hAA55_AA55, 32'h0000_0007, 1, 0, 1, '0);
    apply(32'h0040_2000, 1'b0, 2'b10, 1'b0, 32'hAA55_AA55, 32'h0000_0007, 0, 1, 1, '0);
    apply(32'h7FFF_E000, 1'b1, 2'b00, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a = $urandom;
      bit          w = $urandom_range(0, 1);
      logic [1:0]  m = 2'($urandom_range(0, 3));
      bit          erl = ($urandom_range(0, 3) == 0);
      apply(a, w, m, erl, $urandom, $urandom,
            $urandom_range(0, 1), ($urandom_range(0, 3) != 0), $urandom_range(0, 1), $urandom);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule